// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block stands between the distributor's per-CPU pending vector and one processor. Each cycle it looks at every pending source and drops the ones that are already active or whose priority value is not strictly below the CPU's priority mask. From the sources that remain it picks a winner. A lower priority value wins, and on equal values the lower id wins. While signalling is enabled and a winner exists, the CPU interrupt line is high.

Software uses a 32-bit register port with four word registers. A read of the acknowledge register returns the winner's id. In the same cycle the block marks that id active and pulses a taken strobe with the id, so the distributor can clear its pending bit. When nothing can be taken, the read returns a spurious id above 510, and software discards it. A write of an id to the end-of-interrupt register clears that id's active state. An active id is never signalled again until that write, even if it becomes pending again.

Top module: `icpu_ack_if`

## Requirements
- R1: After reset the interrupt line is low, no source is active, the control register reads 0 and the priority mask reads 0.
- R2: Control register bit 0 enables signalling. While it is 0 the interrupt line stays low and an acknowledge read returns the spurious id. Only bit 0 is stored.
- R3: A source can be signalled only when its 8-bit priority value is numerically below the 8-bit priority mask. An equal value is excluded.
- R4: Among eligible sources the lowest priority value wins, and ties go to the lowest id. The acknowledge read returns the id in bits 9:0 with bits 31:10 zero.
- R5: An acknowledge read that returns a valid id marks that id active and raises takenValid with takenId equal to that id in the same cycle. takenValid is low in every other cycle.
- R6: An active source is neither signalled nor returned by an acknowledge read while it remains pending.
- R7: An end-of-interrupt write whose bits 9:0 name an active id clears its active state, so it can be signalled again.
- R8: An end-of-interrupt write naming an id that is not active, or one at or beyond the source count, changes no state.
- R9: With no eligible source, an acknowledge read returns 1023 (above 510) and changes no state.
- R10: Register word addresses: 0 control, 1 priority mask (bits 7:0), 2 acknowledge (read), 3 end-of-interrupt (write). Control and mask read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pendVec | input | NUM_IRQ | Pending sources routed to this CPU |
| prioFlat | input | NUM_IRQ*8 | Priority value of each source, source i at bits 8i+7:8i |
| regAddr | input | 2 | Register word address |
| rdEn | input | 1 | Register read strobe |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data, valid in the cycle of rdEn |
| irqOut | output | 1 | Interrupt request to the CPU |
| takenValid | output | 1 | Pulses when an acknowledge read takes a source |
| takenId | output | 10 | Id of the source being taken |

## Verification
The hardest state to reach is several sources active at once, each still pending. Here the winner must skip all active ids while lower-priority waiting sources stay ordered. The bench reaches this by acknowledging repeatedly, without end-of-interrupt writes, until the spurious id appears. It compares every returned id with a priority model across hundreds of generated pending and priority patterns, with coarse priority values so that ties occur often. It then retires the sources one by one and checks the line after each write.

// File: rtl/icpu_pkg.sv
`timescale 1ns/1ps
package icpu_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              sigEnable;
    logic [PRIO_W-1:0] prioMask;
    logic              ackTake;
    logic              eoiWrite;
    logic [ID_W-1:0]   eoiId;
  } strobe_t;
endpackage

// File: rtl/icpu_regs.sv
`timescale 1ns/1ps
module icpu_regs
  import icpu_pkg::*;
#(
  parameter int SPUR_ID = 1023
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      regAddr,
  input  logic            rdEn,
  input  logic            wrEn,
  input  logic [31:0]     wrData,
  input  logic            winFound,
  input  logic [ID_W-1:0] winId,
  output logic [31:0]     rdData,
  output strobe_t         strb
);
  regSel_e           sel;
  logic              enReg;
  logic [PRIO_W-1:0] maskReg;
  logic              ackTake;
  logic              unusedWrBits;

  assign sel          = regSel_e'(regAddr);
  assign unusedWrBits = ^wrData[31:ID_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enReg   <= 1'b0;
      maskReg <= '0;
    end else if (wrEn) begin
      if (sel == REG_CTRL)  enReg   <= wrData[0];
      if (sel == REG_PMASK) maskReg <= wrData[PRIO_W-1:0];
    end
  end

  assign ackTake = rdEn && (sel == REG_ACK) && enReg && winFound;

  always_comb begin
    strb.sigEnable = enReg;
    strb.prioMask  = maskReg;
    strb.ackTake   = ackTake;
    strb.eoiWrite  = wrEn && (sel == REG_EOI);
    strb.eoiId     = wrData[ID_W-1:0];
  end

  always_comb begin
    unique case (sel)
      REG_CTRL:  rdData = {31'b0, enReg};
      REG_PMASK: rdData = 32'(maskReg);
      REG_ACK:   rdData = ackTake ? 32'(winId) : 32'(SPUR_ID);
      default:   rdData = '0;
    endcase
  end

  // R9: a read that takes nothing reports an id beyond the valid range
  p_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && sel == REG_ACK && !ackTake) |-> (rdData > 32'd510));

  // R10: the mask changes only on a write to its address
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && sel == REG_PMASK) |=> $stable(maskReg));

  // R2: enable changes only on a control write
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && sel == REG_CTRL) |=> $stable(enReg));
endmodule

// File: rtl/icpu_core.sv
`timescale 1ns/1ps
module icpu_core
  import icpu_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        pendVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  strobe_t                   strb,
  output logic                      irqOut,
  output logic                      winFound,
  output logic [ID_W-1:0]           winId,
  output logic                      takenValid,
  output logic [ID_W-1:0]           takenId
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [PRIO_W-1:0]  prioArr [NUM_IRQ];
  logic [NUM_IRQ-1:0] activeVec;
  logic [NUM_IRQ-1:0] eligible;
  logic [NUM_IRQ-1:0] setMask;
  logic [NUM_IRQ-1:0] clrMask;
  logic [IDX_W-1:0]   winIdx;
  logic [IDX_W-1:0]   eoiIdx;
  logic [PRIO_W-1:0]  bestPrio;
  logic               eoiInRange;
  logic               eoiHit;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
    assign prioArr[g]  = prioFlat[g*PRIO_W +: PRIO_W];
    assign eligible[g] = pendVec[g] && !activeVec[g] && (prioArr[g] < strb.prioMask);
  end

  always_comb begin
    winFound = 1'b0;
    bestPrio = '1;
    winIdx   = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (eligible[i] && (!winFound || prioArr[i] < bestPrio)) begin
        winFound = 1'b1;
        bestPrio = prioArr[i];
        winIdx   = IDX_W'(i);
      end
    end
  end

  assign winId      = ID_W'(winIdx);
  assign irqOut     = strb.sigEnable && winFound;
  assign takenValid = strb.ackTake;
  assign takenId    = winId;

  assign eoiIdx     = strb.eoiId[IDX_W-1:0];
  assign eoiInRange = strb.eoiId < ID_W'(NUM_IRQ);
  assign eoiHit     = strb.eoiWrite && eoiInRange && activeVec[eoiIdx];

  always_comb begin
    setMask = '0;
    clrMask = '0;
    if (strb.ackTake) setMask[winIdx] = 1'b1;
    if (eoiHit)       clrMask[eoiIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) activeVec <= '0;
    else        activeVec <= (activeVec | setMask) & ~clrMask;
  end

  // R5: a taken source is active on the following cycle
  p_take_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    takenValid |=> activeVec[$past(winIdx)]);

  // R7: end-of-interrupt on an active id clears it
  p_eoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoiHit |=> !activeVec[$past(eoiIdx)]);

  // R6: the winner is never an active source
  p_winner_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    winFound |-> !activeVec[winIdx]);

  // R3: the winner lies strictly below the mask
  p_winner_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    winFound |-> (prioArr[winIdx] < strb.prioMask));

  // R8: without a take or a matching end-of-interrupt the active set holds
  p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!takenValid && !eoiHit) |=> $stable(activeVec));
endmodule

// File: rtl/icpu_ack_if.sv
`timescale 1ns/1ps
module icpu_ack_if
  import icpu_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int SPUR_ID = 1023
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        pendVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  logic [1:0]                regAddr,
  input  logic                      rdEn,
  input  logic                      wrEn,
  input  logic [31:0]               wrData,
  output logic [31:0]               rdData,
  output logic                      irqOut,
  output logic                      takenValid,
  output logic [ID_W-1:0]           takenId
);
  strobe_t         strb;
  logic            winFound;
  logic [ID_W-1:0] winId;

  icpu_regs #(.SPUR_ID(SPUR_ID)) i_regs (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .winFound(winFound), .winId(winId),
    .rdData(rdData), .strb(strb)
  );

  icpu_core #(.NUM_IRQ(NUM_IRQ)) i_core (
    .clk(clk), .rst_n(rst_n), .pendVec(pendVec), .prioFlat(prioFlat),
    .strb(strb), .irqOut(irqOut), .winFound(winFound), .winId(winId),
    .takenValid(takenValid), .takenId(takenId)
  );

  // R2: the line is high only with signalling enabled
  p_line_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> !$past(wrEn && regAddr == 2'd0 && !wrData[0]) || $past(!rst_n));
endmodule

// File: tb/test_icpu_ack_if.sv
`timescale 1ns/1ps
module test_icpu_ack_if;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pendVec = '0;
  logic [N*8-1:0] prioFlat = '0;
  logic [1:0]    regAddr = '0;
  logic          rdEn = 1'b0;
  logic          wrEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic          irqOut;
  logic          takenValid;
  logic [9:0]    takenId;

  logic [7:0]    bPrio [N];
  logic [N-1:0]  actModel;
  logic [7:0]    curMask;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  icpu_ack_if #(.NUM_IRQ(N), .SPUR_ID(1023)) i_icpu_ack_if (
    .clk(clk), .rst_n(rst_n), .pendVec(pendVec), .prioFlat(prioFlat),
    .regAddr(regAddr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut), .takenValid(takenValid), .takenId(takenId)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic applyPrio();
    for (int i = 0; i < N; i++) prioFlat[i*8 +: 8] = bPrio[i];
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; #1;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d,
                         output logic tv, output logic [9:0] tid);
    @(negedge clk); regAddr = a; rdEn = 1'b1; #1;
    d = rdData; tv = takenValid; tid = takenId;
    @(negedge clk); rdEn = 1'b0; #1;
  endtask

  function automatic int modelWin(input logic [N-1:0] act);
    int w = -1;
    int bp = 256;
    for (int i = 0; i < N; i++)
      if (pendVec[i] && !act[i] && bPrio[i] < curMask && int'(bPrio[i]) < bp) begin
        w = i; bp = int'(bPrio[i]);
      end
    return w;
  endfunction

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic tv;
    logic [9:0] tid;
    logic [31:0] seed;
    for (int i = 0; i < N; i++) bPrio[i] = 8'd0;
    applyPrio();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;

    // R1 reset state
    chk(irqOut == 1'b0, "R1 line", 32'(irqOut), 0);
    regRead(2'd0, d, tv, tid); chk(d == 0, "R1 ctrl", d, 0);
    regRead(2'd1, d, tv, tid); chk(d == 0, "R1 mask", d, 0);
    regRead(2'd2, d, tv, tid);
    chk(d == 1023 && !tv, "R9 idle ack", d, 1023);

    // R10 register map and readback, R2 only bit0 stored
    regWrite(2'd0, 32'h1); regRead(2'd0, d, tv, tid); chk(d == 1, "R10 ctrl", d, 1);
    regWrite(2'd1, 32'hF0); regRead(2'd1, d, tv, tid); chk(d == 32'hF0, "R10 mask", d, 32'hF0);
    regWrite(2'd0, 32'hFFFF_FFFE); regRead(2'd0, d, tv, tid); chk(d == 0, "R2 bit0 only", d, 0);
    curMask = 8'hF0;

    // R2 enable gating
    bPrio[3] = 8'h10; applyPrio(); pendVec = 16'h0008; #1;
    chk(irqOut == 0, "R2 disabled line", 32'(irqOut), 0);
    regRead(2'd2, d, tv, tid); chk(d == 1023 && !tv, "R2 disabled ack", d, 1023);
    regWrite(2'd0, 32'h1);
    chk(irqOut == 1, "R2 enabled line", 32'(irqOut), 1);

    // R3 sweep of priority against mask
    pendVec = 16'h0020;
    for (int m = 0; m < 5; m++) begin
      logic [7:0] mv;
      mv = (m == 0) ? 8'h00 : (m == 1) ? 8'h10 : (m == 2) ? 8'h80 : (m == 3) ? 8'hF0 : 8'hFF;
      regWrite(2'd1, 32'(mv));
      for (int p = 0; p < 256; p++) begin
        @(negedge clk); bPrio[5] = 8'(p); applyPrio(); #1;
        chk(irqOut == (p < int'(mv)), "R3 mask compare", 32'(irqOut), 32'(p < int'(mv)));
      end
    end
    regWrite(2'd1, 32'h80); bPrio[5] = 8'h80; applyPrio(); #1;
    regRead(2'd2, d, tv, tid); chk(d == 1023, "R3 equal excluded", d, 1023);

    // R4 tie to lowest id
    regWrite(2'd1, 32'hF0); curMask = 8'hF0;
    for (int i = 0; i < N; i++) bPrio[i] = 8'h60;
    bPrio[2] = 8'h40; bPrio[9] = 8'h40; bPrio[12] = 8'h40; applyPrio();
    pendVec = 16'h1204;
    regRead(2'd2, d, tv, tid); chk(d == 2, "R4 tie", d, 2);
    regWrite(2'd3, 32'd2);

    // R5 R6 R7 R8 directed
    pendVec = 16'h0080; bPrio[7] = 8'h20; applyPrio();
    regRead(2'd2, d, tv, tid);
    chk(d == 7, "R5 ack id", d, 7);
    chk(tv && tid == 7, "R5 taken strobe", {22'b0, tid}, 7);
    chk(takenValid == 0, "R5 strobe low", 32'(takenValid), 0);
    chk(irqOut == 0, "R6 active masked", 32'(irqOut), 0);
    regRead(2'd2, d, tv, tid); chk(d == 1023 && !tv, "R6 no re-ack", d, 1023);
    regWrite(2'd3, 32'd9);   chk(irqOut == 0, "R8 eoi other", 32'(irqOut), 0);
    regWrite(2'd3, 32'd300); chk(irqOut == 0, "R8 eoi range", 32'(irqOut), 0);
    regWrite(2'd3, 32'd7);   chk(irqOut == 1, "R7 eoi clears", 32'(irqOut), 1);
    regRead(2'd2, d, tv, tid); chk(d == 7, "R7 re-ack", d, 7);
    regWrite(2'd3, 32'd7);

    // R4/R6/R7 generated sweep with multiple actives
    seed = 32'h1234_5678;
    actModel = '0;
    for (int k = 0; k < 300; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      pendVec = seed[31:16];
      for (int i = 0; i < N; i++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        bPrio[i] = {seed[30:28], 5'b0};
      end
      applyPrio();
      curMask = (k % 4 == 0) ? 8'hF0 : (k % 4 == 1) ? 8'h80 : (k % 4 == 2) ? 8'hFF : 8'h40;
      regWrite(2'd1, 32'(curMask));
      for (int s = 0; s <= N; s++) begin
        int w;
        w = modelWin(actModel);
        chk(irqOut == (w >= 0), "R6 line", 32'(irqOut), 32'(w >= 0));
        regRead(2'd2, d, tv, tid);
        if (w < 0) begin
          chk(d == 1023 && !tv, "R9 sweep spurious", d, 1023);
          break;
        end
        chk(d == 32'(w) && tv, "R4 sweep winner", d, 32'(w));
        actModel[w] = 1'b1;
      end
      for (int i = 0; i < N; i++) begin
        if (actModel[i]) begin
          regWrite(2'd3, 32'(i));
          actModel[i] = 1'b0;
          chk(irqOut == (modelWin(actModel) >= 0), "R7 sweep release",
              32'(irqOut), 32'(modelWin(actModel) >= 0));
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule